// File: doc/BRIEF.md
# Store-Wait Dependence Predictor

This block remembers which loads have earlier been caught reading memory ahead of an older store to the same address, and tells the issue logic to hold those loads back the next time they appear. It keeps a table of one-bit "wait" flags. The table is indexed by a field of the load's program counter. When a load's ordering violation is detected at commit, a trap event carries that load's PC into the block and the matching flag is set. When a load is fetched, its PC is looked up and the flag is returned combinationally. The flag then travels with the load to the issue stage.

At issue, the flag that travelled with the load is presented again together with an indication that older stores are still waiting to issue. While both are true the block raises a hold output, which keeps the load in the issue queue. A free-running period counter empties the whole table at a fixed interval. This stops stale flags from serialising loads that no longer conflict. The predictor does not pair loads with particular stores: one bit per PC slot is the entire state.

Top module: `store_wait_predictor`

## Requirements
- R1: After reset every table entry is clear, so a lookup of any PC returns `lookupWait` = 0.
- R2: A cycle with `trapValid` = 1 sets the entry whose index is `trapPc[IDX_LO+IDX_W-1:IDX_LO]` (bits [11:2] by default). A lookup from the following cycle on returns 1 for that index.
- R3: `lookupWait` is a combinational read of the entry at index `lookupPc[IDX_LO+IDX_W-1:IDX_LO]`. PC bits below `IDX_LO` and above the index field have no effect, so PCs that share the index field alias to the same entry.
- R4: In a cycle with `trapValid` = 0, and no periodic clear, no table entry changes, whatever value `trapPc` holds.
- R5: A set changes only the addressed entry. All other entries keep their values.
- R6: Counting clock edges from the release of reset, the edges numbered CLEAR_PERIOD, 2*CLEAR_PERIOD and so on clear every entry. Entries set before such an edge read 1 up to that edge and read 0 after it.
- R7: When a trap arrives in the same cycle as a periodic clear, the clear wins, and the trapped entry reads 0 afterwards.
- R8: `issueHold` = `issueWaitBit` AND `olderStorePending`, combinationally. It is independent of the table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trapValid | input | 1 | Commit-time ordering trap for a load |
| trapPc | input | PC_W | PC of the trapped load |
| lookupPc | input | PC_W | PC of a load being fetched |
| lookupWait | output | 1 | Wait flag for `lookupPc` |
| issueWaitBit | input | 1 | Wait flag carried by the load at issue |
| olderStorePending | input | 1 | Older stores not yet all issued |
| issueHold | output | 1 | Keep the load in the issue queue |

## Verification
A corrupted entry shows up at `lookupWait` in the very cycle its index is looked up. The bench therefore sweeps every index of a small 16-entry table after each event, with upper and lower PC bits randomised, so a stray set, a missed set or an aliasing error is seen within one cycle of the cause. A period counter that is off by one shows up as flags that survive, or vanish, one edge away from the expected clear edge. The bench checks the table on both sides of that edge. It also lines a trap up exactly with a clear edge to check which of the two wins.

// File: rtl/swp_pkg.sv
package swp_pkg;
  // Strobes from the control path to the flag table.
  typedef struct packed {
    logic setEn;     // set the entry addressed by the trap PC
    logic clearAll;  // empty the whole table this edge
  } swpStrobe_t;
endpackage

// File: rtl/swp_ctrl.sv
module swp_ctrl
  import swp_pkg::*;
#(
  parameter int CLEAR_PERIOD = 16384
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trapValid,
  output swpStrobe_t strobe
);
  localparam int CNT_W = (CLEAR_PERIOD > 2) ? $clog2(CLEAR_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CLEAR_PERIOD - 1);

  logic [CNT_W-1:0] periodCnt;
  logic             wrapNow;

  assign wrapNow = (periodCnt == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        periodCnt <= '0;
    else if (wrapNow) periodCnt <= '0;
    else              periodCnt <= periodCnt + CNT_W'(1);
  end

  // The periodic clear takes priority over a trap in the same cycle (R7).
  always_comb begin
    strobe.clearAll = wrapNow;
    strobe.setEn    = trapValid & ~wrapNow;
  end

  // R6: clears are spaced, never back to back.
  assert_clear_spacing_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> !strobe.clearAll);

  // R6: the period counter never leaves its range.
  assert_count_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    periodCnt <= LAST_CNT);
endmodule

// File: rtl/swp_table.sv
module swp_table
  import swp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_LO = 2,
  parameter int IDX_W  = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  swpStrobe_t      strobe,
  input  logic [PC_W-1:0] trapPc,
  input  logic [PC_W-1:0] lookupPc,
  output logic            lookupWait,
  input  logic            issueWaitBit,
  input  logic            olderStorePending,
  output logic            issueHold
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] tableQ;
  logic [IDX_W-1:0]   trapIdx;
  logic [IDX_W-1:0]   lookupIdx;
  logic               unusedPcBits;

  assign trapIdx      = trapPc[IDX_LO +: IDX_W];
  assign lookupIdx    = lookupPc[IDX_LO +: IDX_W];
  assign unusedPcBits = ^{trapPc, lookupPc};

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                         tableQ[g] <= 1'b0;
      else if (strobe.clearAll)                          tableQ[g] <= 1'b0;
      else if (strobe.setEn && trapIdx == IDX_W'(g))     tableQ[g] <= 1'b1;
    end
  end

  assign lookupWait = tableQ[lookupIdx];
  assign issueHold  = issueWaitBit & olderStorePending;

  // R2: a set lands in the addressed entry.
  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setEn |=> tableQ[$past(trapIdx)]);

  // R4: no strobe, no change.
  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.setEn && !strobe.clearAll) |=> $stable(tableQ));

  // R5: a set flips at most one entry.
  assert_single_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setEn |=> ($countones(tableQ ^ $past(tableQ)) <= 1));

  // R6/R7: a clear leaves nothing set, whatever else arrived with it.
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (tableQ == '0));
endmodule

// File: rtl/store_wait_predictor.sv
module store_wait_predictor
  import swp_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int IDX_LO       = 2,
  parameter int IDX_W        = 10,
  parameter int CLEAR_PERIOD = 16384
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trapValid,
  input  logic [PC_W-1:0] trapPc,
  input  logic [PC_W-1:0] lookupPc,
  output logic            lookupWait,
  input  logic            issueWaitBit,
  input  logic            olderStorePending,
  output logic            issueHold
);
  swpStrobe_t strobe;

  swp_ctrl #(.CLEAR_PERIOD(CLEAR_PERIOD)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .trapValid (trapValid),
    .strobe    (strobe)
  );

  swp_table #(.PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W)) u_table (
    .clk               (clk),
    .rstN              (rstN),
    .strobe            (strobe),
    .trapPc            (trapPc),
    .lookupPc          (lookupPc),
    .lookupWait        (lookupWait),
    .issueWaitBit      (issueWaitBit),
    .olderStorePending (olderStorePending),
    .issueHold         (issueHold)
  );
endmodule

// File: tb/store_wait_predictor_bench.sv
`timescale 1ns/1ps
module store_wait_predictor_bench;
  localparam int PC_W = 16, IDX_LO = 2, IDX_W = 4, PERIOD = 97;
  localparam int ENTRIES = 1 << IDX_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic trapValid = 1'b0, issueWaitBit = 1'b0, olderStorePending = 1'b0;
  logic [PC_W-1:0] trapPc = '0, lookupPc = '0;
  logic lookupWait, issueHold;

  int testsRun = 0, testsFailed = 0;
  bit done = 1'b0;

  // Bench-side reference: entry flags and edge count since reset release.
  logic [ENTRIES-1:0] refTable = '0;
  int edgeCnt = 0;

  always #5 clk = ~clk;

  store_wait_predictor #(.PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W),
                         .CLEAR_PERIOD(PERIOD)) u_store_wait_predictor (
    .clk(clk), .rstN(rstN), .trapValid(trapValid), .trapPc(trapPc),
    .lookupPc(lookupPc), .lookupWait(lookupWait), .issueWaitBit(issueWaitBit),
    .olderStorePending(olderStorePending), .issueHold(issueHold));

  always @(posedge clk) begin
    if (!rstN) begin
      refTable = '0;
      edgeCnt  = 0;
    end else begin
      edgeCnt = edgeCnt + 1;
      if (edgeCnt % PERIOD == 0) refTable = '0;
      else if (trapValid) refTable[trapPc[IDX_LO +: IDX_W]] = 1'b1;
    end
  end

  function automatic logic [PC_W-1:0] pcFor(int idx);
    logic [PC_W-1:0] pc = PC_W'($urandom);
    pc[IDX_LO +: IDX_W] = IDX_W'(idx);
    return pc;
  endfunction

  task automatic check(logic got, logic exp, string tag);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sweepAll(string tag);
    for (int i = 0; i < ENTRIES; i++) begin
      lookupPc = pcFor(i);
      #1;
      check(lookupWait, refTable[i], tag);
    end
  endtask

  task automatic lookupOne(int idx, logic exp, string tag);
    lookupPc = pcFor(idx);
    #1;
    check(lookupWait, exp, tag);
  endtask

  task automatic trapOnce(int idx);
    trapPc = pcFor(idx);
    trapValid = 1'b1;
    step();
    trapValid = 1'b0;
    trapPc = PC_W'($urandom);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    #200000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: empty table after reset.
    for (int i = 0; i < ENTRIES; i++) lookupOne(i, 1'b0, "R1 reset lookup");

    // R4: trap PC toggling without trapValid changes nothing.
    for (int c = 0; c < 6; c++) begin
      trapPc = PC_W'($urandom);
      step();
    end
    sweepAll("R4 idle trapPc");

    // R2/R5: set odd entries one by one, sweep the whole table each time.
    for (int i = 1; i < ENTRIES; i += 2) begin
      trapOnce(i);
      lookupOne(i, refTable[i], "R2 set visible next cycle");
      sweepAll("R5 neighbours untouched");
    end

    // R3: aliasing, the same index under many upper/lower PC patterns.
    for (int k = 0; k < 8; k++) begin
      lookupOne(3, refTable[3], "R3 alias odd");
      lookupOne(6, refTable[6], "R3 alias even");
    end

    // R7: trap aligned with a clear edge.
    while ((edgeCnt + 1) % PERIOD != 0) step();
    trapOnce(5);
    lookupOne(5, 1'b0, "R7 clear beats set");
    sweepAll("R7 table empty");

    // R6: flags survive until the clear edge, then vanish.
    trapOnce(3);
    trapOnce(9);
    trapOnce(14);
    while ((edgeCnt + 1) % PERIOD != 0) step();
    lookupOne(3, 1'b1, "R6 before clear");
    lookupOne(9, 1'b1, "R6 before clear");
    lookupOne(14, 1'b1, "R6 before clear");
    step();
    for (int i = 0; i < ENTRIES; i++) lookupOne(i, 1'b0, "R6 after clear");

    // R2/R5: set every entry, then check the full table.
    for (int i = 0; i < ENTRIES; i++) trapOnce(i);
    sweepAll("R2 all set");

    // R8: gate truth table, with the table in two different states.
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) begin
        while ((edgeCnt + 1) % PERIOD != 0) step();
        step();
      end
      for (int v = 0; v < 4; v++) begin
        issueWaitBit = v[0];
        olderStorePending = v[1];
        #1;
        check(issueHold, v[0] & v[1], "R8 issue gate");
      end
    end
    finishRun();
  end
endmodule